// File: doc/BRIEF.md
# LCD Power-Up Sequence Player

This block brings a smart LCD panel from power-on to pixel streaming. It sits in front of a register-write bus engine, which turns each request into panel bus cycles, and does all the sequencing. The bus engine reports that it is working through a busy flag. After a start pulse the player reads the panel identification register. It then toggles the panel reset line with fixed waits. Next it plays a constant table of register writes, each followed by an optional wait in milliseconds. Last, it sends the memory-write command on its own and hands the bus to a pixel streamer.

Each table entry holds an 8-bit register index, a 16-bit value and an 8-bit delay in milliseconds. Each entry becomes two requests: a command word carrying the index, then a data word carrying the value. The millisecond time base comes from the clock-frequency parameter, so one millisecond lasts `CLK_HZ/1000` cycles. When `done` is high, register-select stays high and every later word on the bus is 16-bit pixel data.

Top module: `lcd_init_player`

## Requirements
- R1: After `rst_n` is released, `done` and `req` are low and `panel_rst_n` is low. The block issues no request until `start` is pulsed.
- R2: The first request after `start` is a read (`req_rd`=1, `req_rs`=0, `req_word`=0x0000), which reads the panel identification register. The `rd_data` value present when busy drops after this read is held on `panel_id`.
- R3: After the read completes, `panel_rst_n` goes high, then low, then high. There are `RST_MS` milliseconds before the first change, between changes, and after the last change before the first table request. Each interval lasts between RST_MS·CLK_HZ/1000 and 3 cycles more.
- R4: Each of the 51 table entries, in table order, produces a command request (`req_rs`=0, `req_word` = {8'h00, index}) and then a data request (`req_rs`=1, `req_word` = value). The table begins with index 0xE5 / value 0x78F0 and ends with index 0x07 / value 0x0173.
- R5: Some entries have a delay: the first write of 0x13 has 20 ms. The second writes of 0x11 and 0x12, and the entries for 0x29 and 0x2B, have 50 ms. After busy falls on such an entry's data write, the next request waits D·CLK_HZ/1000 cycles and at most 3 cycles more.
- R6: An entry with zero delay goes on at once: the next request comes 1 or 2 cycles after busy falls.
- R7: `req` is a single-cycle pulse raised only while `bus_busy` is low. The bus engine raises `bus_busy` in the cycle after `req` and holds it until it finishes. The block issues no new request before then.
- R8: After the last entry, the block sends one command request with word 0x0022 and no data word. `done` then rises and stays high, with no further requests, until `start`. A high `done` means register-select is held high and the bus carries 16-bit pixel words.
- R9: A `start` pulse during the sequence abandons it. In the next cycle `done` is low and `panel_rst_n` is low, and the whole sequence restarts from the identification read. That read waits until `bus_busy` is clear.
- R10: A `start` pulse after `done` restarts the full sequence the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse: run (or rerun) the whole sequence |
| bus_busy | input | 1 | Bus engine is executing a request |
| rd_data | input | 16 | Data returned by the bus engine for a read |
| req | output | 1 | Single-cycle request to the bus engine |
| req_rd | output | 1 | Request is a read |
| req_rs | output | 1 | Register-select: 0 command/index, 1 data |
| req_word | output | 16 | Word to send |
| panel_rst_n | output | 1 | Panel reset line level |
| panel_id | output | 16 | Captured identification word |
| done | output | 1 | Streaming mode: RS high, 16-bit pixel words |

## Verification
A wrong table pointer or a wrong state shows up at the ports on the very next request. The word, the select bit or the read flag differ from the expected stream, or a request appears after `done`. A timer that loads the wrong count, or ticks at the wrong rate, moves the next request or the next reset-line edge outside its cycle window. The player then runs ahead of the panel or stalls behind it. This is measured from busy falling, so a delay error is caught within one entry. A broken busy handshake shows as a request while the engine is busy, or as a request that never comes.

// File: rtl/lcd_init_player.sv
module lcd_init_player #(
  parameter int CLK_HZ = 50_000_000,
  parameter int RST_MS = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        bus_busy,
  input  logic [15:0] rd_data,
  output logic        req,
  output logic        req_rd,
  output logic        req_rs,
  output logic [15:0] req_word,
  output logic        panel_rst_n,
  output logic [15:0] panel_id,
  output logic        done
);
  localparam int CPM   = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
  localparam int CW    = (CPM > 1) ? $clog2(CPM) : 1;
  localparam int N_ENT = 51;
  localparam int EW    = $clog2(N_ENT);

  typedef enum logic [3:0] {
    S_IDLE, S_IDRQ, S_IDWT, S_RST, S_IXRQ, S_IXWT,
    S_VLRQ, S_VLWT, S_DLY, S_MWRQ, S_MWWT, S_DONE
  } st_t;

  function automatic logic [31:0] rom(input logic [EW-1:0] i);
    case (i)
      0:  rom = 32'hE50078F0;  1:  rom = 32'hE3003008;  2:  rom = 32'hE7000012;
      3:  rom = 32'hEF001231;  4:  rom = 32'h00000001;  5:  rom = 32'h01000100;
      6:  rom = 32'h02000700;  7:  rom = 32'h03001030;  8:  rom = 32'h04000000;
      9:  rom = 32'h08000207;  10: rom = 32'h09000000;  11: rom = 32'h0A000000;
      12: rom = 32'h0C000000;  13: rom = 32'h0D000000;  14: rom = 32'h0F000000;
      15: rom = 32'h10000000;  16: rom = 32'h11000007;  17: rom = 32'h12000000;
      18: rom = 32'h13140000;  19: rom = 32'h10001290;  20: rom = 32'h11320007;
      21: rom = 32'h12320019;  22: rom = 32'h13001700;  23: rom = 32'h29320014;
      24: rom = 32'h20000000;  25: rom = 32'h21000000;  26: rom = 32'h30000504;
      27: rom = 32'h31000007;  28: rom = 32'h32000006;  29: rom = 32'h35000106;
      30: rom = 32'h36000202;  31: rom = 32'h37000504;  32: rom = 32'h38000500;
      33: rom = 32'h39000706;  34: rom = 32'h3C000204;  35: rom = 32'h3D000202;
      36: rom = 32'h50000000;  37: rom = 32'h510000EF;  38: rom = 32'h52000000;
      39: rom = 32'h5300013F;  40: rom = 32'h6000A700;  41: rom = 32'h61000001;
      42: rom = 32'h6A000000;  43: rom = 32'h2B32000D;  44: rom = 32'h90000011;
      45: rom = 32'h92000600;  46: rom = 32'h93000003;  47: rom = 32'h95000110;
      48: rom = 32'h97000000;  49: rom = 32'h98000000;  50: rom = 32'h07000173;
      default: rom = 32'h0;
    endcase
  endfunction

  st_t           state;
  logic          armed;
  logic [EW-1:0] ent;
  logic [7:0]    ms_left;
  logic [CW-1:0] cyc;
  logic [1:0]    rst_ph;
  logic          rst_line;
  logic [15:0]   id_q;
  logic [31:0]   ent_w;

  assign ent_w       = rom(ent);
  assign req_rd      = (state == S_IDRQ);
  assign req_rs      = (state == S_VLRQ);
  assign req         = !bus_busy && (state == S_IDRQ || state == S_IXRQ ||
                                     state == S_VLRQ || state == S_MWRQ);
  assign req_word    = (state == S_VLRQ) ? ent_w[15:0] :
                       (state == S_IXRQ) ? {8'h00, ent_w[31:24]} :
                       (state == S_MWRQ) ? 16'h0022 : 16'h0000;
  assign done        = (state == S_DONE);
  assign panel_rst_n = rst_line;
  assign panel_id    = id_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; armed <= 1'b0; ent <= '0; ms_left <= '0;
      cyc <= '0; rst_ph <= '0; rst_line <= 1'b0; id_q <= '0;
    end else if (start) begin
      state <= S_IDRQ; armed <= 1'b0; ent <= '0; ms_left <= '0;
      cyc <= '0; rst_ph <= '0; rst_line <= 1'b0;
    end else begin
      if ((state == S_RST || state == S_DLY) && ms_left != 0) begin
        if (cyc == CW'(CPM - 1)) begin
          cyc <= '0;
          ms_left <= ms_left - 8'd1;
        end else cyc <= cyc + 1'b1;
      end
      case (state)
        S_IDRQ: if (!bus_busy) begin state <= S_IDWT; armed <= 1'b0; end
        S_IXRQ: if (!bus_busy) begin state <= S_IXWT; armed <= 1'b0; end
        S_VLRQ: if (!bus_busy) begin state <= S_VLWT; armed <= 1'b0; end
        S_MWRQ: if (!bus_busy) begin state <= S_MWWT; armed <= 1'b0; end
        S_IDWT, S_IXWT, S_VLWT, S_MWWT:
          if (!armed) armed <= 1'b1;
          else if (!bus_busy) begin
            case (state)
              S_IDWT: begin
                id_q <= rd_data; state <= S_RST;
                ms_left <= 8'(RST_MS); cyc <= '0;
              end
              S_IXWT: state <= S_VLRQ;
              S_VLWT:
                if (ent_w[23:16] != 8'd0) begin
                  state <= S_DLY; ms_left <= ent_w[23:16]; cyc <= '0;
                end else if (ent == EW'(N_ENT - 1)) state <= S_MWRQ;
                else begin ent <= ent + 1'b1; state <= S_IXRQ; end
              default: state <= S_DONE;
            endcase
          end
        S_RST:
          if (ms_left == 0) begin
            if (rst_ph == 2'd3) state <= S_IXRQ;
            else begin
              rst_line <= ~rst_line; rst_ph <= rst_ph + 2'd1;
              ms_left <= 8'(RST_MS); cyc <= '0;
            end
          end
        S_DLY:
          if (ms_left == 0) begin
            if (ent == EW'(N_ENT - 1)) state <= S_MWRQ;
            else begin ent <= ent + 1'b1; state <= S_IXRQ; end
          end
        default: ;
      endcase
    end
  end

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !start) |=> !req);
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  p_quiet_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req);
  p_line_up_table_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !req_rd) |-> panel_rst_n);
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && !panel_rst_n));
  p_read_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && req_rd) |-> (req_word == 16'h0000 && !req_rs));
endmodule

// File: tb/lcd_init_player_tb_top.sv
module lcd_init_player_tb_top;
  localparam int CLK_HZ = 4000;
  localparam int RST_MS = 50;
  localparam int CPM    = CLK_HZ / 1000;
  localparam int RW     = RST_MS * CPM;

  localparam logic [31:0] TBL [51] = '{
    32'hE50078F0, 32'hE3003008, 32'hE7000012, 32'hEF001231, 32'h00000001, 32'h01000100,
    32'h02000700, 32'h03001030, 32'h04000000, 32'h08000207, 32'h09000000, 32'h0A000000,
    32'h0C000000, 32'h0D000000, 32'h0F000000, 32'h10000000, 32'h11000007, 32'h12000000,
    32'h13140000, 32'h10001290, 32'h11320007, 32'h12320019, 32'h13001700, 32'h29320014,
    32'h20000000, 32'h21000000, 32'h30000504, 32'h31000007, 32'h32000006, 32'h35000106,
    32'h36000202, 32'h37000504, 32'h38000500, 32'h39000706, 32'h3C000204, 32'h3D000202,
    32'h50000000, 32'h510000EF, 32'h52000000, 32'h5300013F, 32'h6000A700, 32'h61000001,
    32'h6A000000, 32'h2B32000D, 32'h90000011, 32'h92000600, 32'h93000003, 32'h95000110,
    32'h97000000, 32'h98000000, 32'h07000173 };

  typedef struct packed {
    logic rd; logic rs; logic [15:0] w; logic [15:0] mn; logic [15:0] mx;
  } item_t;

  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] rd_val = 16'h5A3C;
  logic [3:0]  lat = 4'd2, bcnt;
  logic bus_busy, req, req_rd, req_rs, panel_rst_n, done;
  logic [15:0] req_word, panel_id;
  int total = 0, bad = 0, cyc = 0, pops = 0;
  item_t exp_q[$];

  always #10 clk = ~clk;

  lcd_init_player #(.CLK_HZ(CLK_HZ), .RST_MS(RST_MS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_busy(bus_busy), .rd_data(rd_val),
    .req(req), .req_rd(req_rd), .req_rs(req_rs), .req_word(req_word),
    .panel_rst_n(panel_rst_n), .panel_id(panel_id), .done(done));

  always @(posedge clk)
    if (!rst_n) bcnt <= 0;
    else if (req) bcnt <= lat;
    else if (bcnt != 0) bcnt <= bcnt - 1;
  assign bus_busy = (bcnt != 0);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_run();
    item_t it;
    it = '{rd:1, rs:0, w:16'h0, mn:0, mx:16'hFFFF};
    exp_q.push_back(it);
    for (int i = 0; i < 51; i++) begin
      int d;
      d = (i == 0) ? 0 : int'(TBL[i-1][23:16]);
      it = '{rd:0, rs:0, w:{8'h00, TBL[i][31:24]}, mn:0, mx:0};
      if (i == 0) it.mx = 16'hFFFF;
      else if (d == 0) begin it.mn = 1; it.mx = 2; end
      else begin it.mn = 16'(d * CPM); it.mx = 16'(d * CPM + 3); end
      exp_q.push_back(it);
      it = '{rd:0, rs:1, w:TBL[i][15:0], mn:1, mx:2};
      exp_q.push_back(it);
    end
    it = '{rd:0, rs:0, w:16'h0022, mn:1, mx:2};
    exp_q.push_back(it);
  endtask

  int  fall_cyc = 0, t_idfall = 0, nedge = 0, t_first = 0;
  int  t_edge [3];
  bit  prev_busy = 0, prev_line = 0, id_pend = 0, first_seen = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_busy && !bus_busy) begin
        fall_cyc = cyc;
        if (id_pend) begin
          id_pend = 0; t_idfall = cyc; nedge = 0; first_seen = 0;
        end
      end
      if (panel_rst_n != prev_line && nedge < 3) begin
        t_edge[nedge] = cyc; nedge++;
      end
      if (req) begin
        check(!bus_busy, "R7 req while busy", bus_busy, 0);
        if (req_rd) id_pend = 1;
        else if (!first_seen) begin first_seen = 1; t_first = cyc; end
        if (exp_q.size() == 0) check(0, "R8 unexpected request", req_word, 0);
        else begin
          item_t e;
          e = exp_q.pop_front();
          pops++;
          check(req_rd == e.rd && req_rs == e.rs && req_word == e.w,
                e.rd ? "R2 read request" : (e.w == 16'h0022 && !e.rs) ? "R8 memory-write cmd" : "R4 table word",
                {req_rd, req_rs, req_word}, {e.rd, e.rs, e.w});
          if (e.mx != 16'hFFFF)
            check((cyc - fall_cyc) >= int'(e.mn) && (cyc - fall_cyc) <= int'(e.mx),
                  (e.mn > 2) ? "R5 delay window" : "R6 zero-delay gap",
                  cyc - fall_cyc, e.mn);
        end
      end
    end
    prev_busy = bus_busy;
    prev_line = panel_rst_n;
  end

  task automatic check_reset_pattern();
    check(nedge == 3, "R3 edge count", nedge, 3);
    check(t_edge[0] - t_idfall >= RW && t_edge[0] - t_idfall <= RW + 3, "R3 first wait", t_edge[0] - t_idfall, RW);
    check(t_edge[1] - t_edge[0] >= RW && t_edge[1] - t_edge[0] <= RW + 3, "R3 second wait", t_edge[1] - t_edge[0], RW);
    check(t_edge[2] - t_edge[1] >= RW && t_edge[2] - t_edge[1] <= RW + 3, "R3 third wait", t_edge[2] - t_edge[1], RW);
    check(t_first - t_edge[2] >= RW && t_first - t_edge[2] <= RW + 3, "R3 final wait", t_first - t_edge[2], RW);
    check(panel_rst_n == 1'b1, "R3 final level", panel_rst_n, 1);
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(!done && !req && !panel_rst_n, "R1 reset state", {done, req, panel_rst_n}, 0);
    repeat (20) @(negedge clk);
    check(!req && !done && pops == 0, "R1 idle until start", pops, 0);

    lat = 4'd2; rd_val = 16'h5A3C;
    push_run();
    pulse_start();
    wait (done);
    @(negedge clk);
    check(exp_q.size() == 0, "R8 stream consumed", exp_q.size(), 0);
    check(panel_id == 16'h5A3C, "R2 id capture", panel_id, 16'h5A3C);
    check_reset_pattern();
    repeat (40) @(negedge clk);
    check(done == 1'b1, "R8 done stays high", done, 1);

    lat = 4'd5; rd_val = 16'hC0DE;
    push_run();
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
    @(negedge clk);
    check(!done && !panel_rst_n, "R10 restart after done", {done, panel_rst_n}, 0);
    wait (done);
    @(negedge clk);
    check(exp_q.size() == 0, "R10 second run consumed", exp_q.size(), 0);
    check(panel_id == 16'hC0DE, "R2 id second value", panel_id, 16'hC0DE);
    check_reset_pattern();

    lat = 4'd3; rd_val = 16'h1357;
    push_run();
    pulse_start();
    wait (pops >= 2 * 105 + 30);
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
    exp_q.delete();
    push_run();
    @(negedge clk);
    check(!done && !panel_rst_n, "R9 abort mid-run", {done, panel_rst_n}, 0);
    wait (done);
    @(negedge clk);
    check(exp_q.size() == 0, "R9 rerun consumed", exp_q.size(), 0);
    check(panel_id == 16'h1357, "R9 id after rerun", panel_id, 16'h1357);
    check_reset_pattern();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule